// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block gives software a word-wide register window onto a bank of general-purpose pins. The pin count is a parameter and a multiple of 32; counts such as 64, 96 and 192 are typical. The registers are grouped by function, with one 32-bit word per 32 pins in each group. The block drives an output value and an output enable for every pad. It samples each pad input through a two-flop synchronizer. It also holds a 2-bit function selector per pin and exports it to the pad multiplexer, which lives outside this block.

The bus is a plain single-cycle port. A write takes effect at the clock edge where `bus_valid` and `bus_write` are both high. Read data is combinational from `bus_addr`. Output levels are changed through a write-one-to-set word and a write-one-to-clear word. A single pin can therefore be raised or lowered without a read-modify-write. The direction and function-select words are ordinary read/write storage.

The window holds eight groups, given here by group number: 0 pin level, 1 direction, 2 set, 3 clear, 4 to 6 reserved, 7 function select. Edge detection is not part of this block, so groups 4 to 6 hold no storage.

Top module: `gpio_bank_regs`

## Requirements
- R1: With NW = NPINS/32, the word for group g and pin word w sits at byte address (g*NW + w)*4, and pin p sits at bit p mod 32 of word p/32. The function-select group starts at byte 7*NW*4 and has 2*NW words. Address bits 1:0 are ignored.
- R2: A level word (group 0) reads the pad inputs through two flops. A pad value present before clock edge k is read back after edge k+1 and not before.
- R3: Writes to the level group change no output and no register.
- R4: Writing a word of the set group (group 2) drives `pad_out` high for every 1 bit of that word. 0 bits leave the pin unchanged.
- R5: Writing a word of the clear group (group 3) drives `pad_out` low for every 1 bit of that word. 0 bits leave the pin unchanged.
- R6: The set and clear words always read as zero.
- R7: A direction word (group 1) reads back what was written and appears on `pad_oe`. A 1 makes the pin an output and a 0 makes it an input.
- R8: Pin p's function select is the 2-bit field at bits (p mod 16)*2+1 : (p mod 16)*2 of function-select word p/16. It appears on `alt_sel[2p+1:2p]` and reads back. The value 0 means plain GPIO.
- R9: While reset is low, `pad_out`, `pad_oe`, `alt_sel` and both synchronizer stages are held at zero.
- R10: The reserved groups 4 to 6 read zero, and writes to them change nothing.
- R11: A word index of 9*NW or above reads zero, and writes to it change nothing.
- R12: A write takes effect only when both `bus_valid` and `bus_write` are high. The result shows on the outputs after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address, AW = clog2(9*NW*4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Output value for each pad |
| pad_oe | output | NPINS | Output enable for each pad |
| alt_sel | output | 2*NPINS | 2-bit function select per pin |

## Verification
The checker takes the bus address and control to be stable around each clock edge. It also assumes only one access per cycle, so a set and a clear of the same word never coincide. The bench drives every input on the falling edge and issues one access at a time to meet this.

The synchronizer property relates the level read to the pad input two edges earlier. The bench therefore changes `pad_in` only in a dedicated latency step and holds it steady during the register sweep. That sweep covers every reachable word index with two data patterns and reads the whole window back after each write.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NPINS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [$clog2(9*(NPINS/32)*4)-1:0] bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [2*NPINS-1:0] alt_sel
);
  localparam int NW = NPINS / 32;
  localparam int AW = $clog2(9 * NW * 4);
  localparam int WW = AW - 2;

  logic [WW-1:0]      widx;
  logic [1:0]         addr_lsb_unused;
  logic [NPINS-1:0]   sync1_q, sync2_q, out_q, dir_q;
  logic [2*NPINS-1:0] alt_q;
  logic               wr_en;

  assign widx            = bus_addr[AW-1:2];
  assign addr_lsb_unused = bus_addr[1:0];
  assign wr_en           = bus_valid && bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      alt_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NW; w++) begin
        if (widx == WW'(NW + w))   dir_q[w*32 +: 32] <= bus_wdata;
        if (widx == WW'(2*NW + w)) out_q[w*32 +: 32] <= out_q[w*32 +: 32] | bus_wdata;
        if (widx == WW'(3*NW + w)) out_q[w*32 +: 32] <= out_q[w*32 +: 32] & ~bus_wdata;
      end
      for (int w = 0; w < 2*NW; w++)
        if (widx == WW'(7*NW + w)) alt_q[w*32 +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++) begin
      if (widx == WW'(w))      bus_rdata = sync2_q[w*32 +: 32];
      if (widx == WW'(NW + w)) bus_rdata = dir_q[w*32 +: 32];
    end
    for (int w = 0; w < 2*NW; w++)
      if (widx == WW'(7*NW + w)) bus_rdata = alt_q[w*32 +: 32];
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign alt_sel = alt_q;
endmodule

module gpio_bank_regs_chk #(
  parameter int NPINS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [$clog2(9*(NPINS/32)*4)-1:0] bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NPINS-1:0]   pad_in,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   pad_oe,
  input logic [2*NPINS-1:0] alt_sel
);
  localparam int NW = NPINS / 32;
  localparam int AW = $clog2(9 * NW * 4);
  localparam int WW = AW - 2;

  logic [WW-1:0] wi;
  logic [1:0]    since_rst;
  logic          acc_wr, acc_rd;

  assign wi     = bus_addr[AW-1:2];
  assign acc_wr = bus_valid && bus_write;
  assign acc_rd = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (pad_out == '0 && pad_oe == '0 && alt_sel == '0));

  // R2
  level_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && wi == WW'(0) && since_rst >= 2'd2) |-> bus_rdata == $past(pad_in[31:0], 2));

  // R3
  level_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wi == WW'(0)) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(alt_sel)));

  // R4
  set_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wi == WW'(2*NW)) |=> ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5
  clr_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wi == WW'(3*NW)) |=> ((pad_out[31:0] & $past(bus_wdata)) == '0));

  // R6
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && wi == WW'(2*NW)) |-> bus_rdata == '0);

  // R7
  dir_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wi == WW'(NW)) |=> pad_oe[31:0] == $past(bus_wdata));

  // R8
  alt_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wi == WW'(7*NW)) |=> alt_sel[31:0] == $past(bus_wdata));

  // R12
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> ($stable(pad_out) && $stable(pad_oe) && $stable(alt_sel)));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel)
);

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  localparam int NPINS = 64;
  localparam int NW    = NPINS / 32;
  localparam int AW    = $clog2(9 * NW * 4);
  localparam int NWIDX = 1 << (AW - 2);

  logic clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NPINS-1:0] pad_in, pad_out, pad_oe;
  logic [2*NPINS-1:0] alt_sel;

  logic [NPINS-1:0]   m_lvl, m_out, m_dir;
  logic [2*NPINS-1:0] m_alt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_bank_regs #(.NPINS(NPINS)) u_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_rd(input int w);
    if (w < NW)                        return m_lvl[w*32 +: 32];
    if (w < 2*NW)                      return m_dir[(w-NW)*32 +: 32];
    if (w >= 7*NW && w < 9*NW)         return m_alt[(w-7*NW)*32 +: 32];
    return 32'h0;
  endfunction

  task automatic mdl_wr(input int w, input logic [31:0] d);
    if (w >= NW && w < 2*NW)        m_dir[(w-NW)*32 +: 32] = d;
    else if (w >= 2*NW && w < 3*NW) m_out[(w-2*NW)*32 +: 32] |= d;
    else if (w >= 3*NW && w < 4*NW) m_out[(w-3*NW)*32 +: 32] &= ~d;
    else if (w >= 7*NW && w < 9*NW) m_alt[(w-7*NW)*32 +: 32] = d;
  endtask

  task automatic wr(input int w, input int lsb, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = AW'(w*4 + lsb); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    mdl_wr(w, d);
  endtask

  task automatic rd_chk(input int w, input string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = AW'(w*4);
    #1 chk(bus_rdata == mdl_rd(w), tag, 128'(bus_rdata), 128'(mdl_rd(w)));
  endtask

  task automatic outs_chk(input string tag);
    chk(pad_out == m_out, {tag, " pad_out"}, 128'(pad_out), 128'(m_out));
    chk(pad_oe == m_dir, {tag, " pad_oe"}, 128'(pad_oe), 128'(m_dir));
    chk(alt_sel == m_alt, {tag, " alt_sel"}, alt_sel, m_alt);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NPINS-1:0] p0, p1;
    p0 = 64'h1234_5678_9ABC_DEF0;
    p1 = 64'hC3C3_0FF0_5AA5_7E81;
    pad_in = p0;
    m_out = '0; m_dir = '0; m_alt = '0; m_lvl = p0;
    repeat (3) @(negedge clk);
    outs_chk("R9 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    rd_chk(0, "R2 level w0");
    rd_chk(1, "R2 level w1");

    // R2 latency: new pad value visible after the second edge only
    @(negedge clk);
    pad_in = p1; bus_valid = 1; bus_write = 0; bus_addr = '0;
    @(negedge clk); #1
    chk(bus_rdata == p0[31:0], "R2 one edge", 128'(bus_rdata), 128'(p0[31:0]));
    @(negedge clk); #1
    chk(bus_rdata == p1[31:0], "R2 two edges", 128'(bus_rdata), 128'(p1[31:0]));
    m_lvl = p1;

    // R12 write without strobe
    @(negedge clk);
    bus_valid = 0; bus_write = 1; bus_addr = AW'(NW*4); bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_write = 0;
    outs_chk("R12 no valid");
    rd_chk(NW, "R12 dir readback");

    // R4 / R5 single pin 40
    wr(2*NW + 1, 0, 32'h0000_0100);
    chk(pad_out[40] == 1'b1, "R4 pin40 set", 128'(pad_out), 128'(m_out));
    wr(2*NW + 1, 0, 32'h0000_0000);
    chk(pad_out[40] == 1'b1, "R4 zero keeps", 128'(pad_out), 128'(m_out));
    wr(3*NW + 1, 0, 32'h0000_0100);
    chk(pad_out[40] == 1'b0, "R5 pin40 clear", 128'(pad_out), 128'(m_out));

    // R8 pin 21 field at word 1 bits 11:10
    wr(7*NW + 1, 0, 32'h0000_0C00);
    chk(alt_sel[43:42] == 2'b11, "R8 pin21 field", alt_sel, m_alt);
    rd_chk(7*NW + 1, "R8 readback");

    // R1 R3 R6 R7 R10 R11 sweep over every word index with two patterns
    for (int w = 0; w < NWIDX; w++) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] d;
        d = 32'hA5C3_0F96 ^ (32'h0101_0101 * w);
        if (k == 1) d = ~d;
        wr(w, (w + k) % 4, d);
        outs_chk($sformatf("R1 R3 R4 R5 R7 R8 R10 R11 w%0d", w));
        for (int r = 0; r < NWIDX; r++)
          rd_chk(r, $sformatf("R1 R6 R10 R11 after w%0d read %0d", w, r));
      end
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule